// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block sits in a core's local interrupt controller and turns a write of the interrupt command word into interrupt traffic. Each write carries a vector, a 3-bit delivery mode, a trigger bit, a destination core ID and a 2-bit shorthand. Depending on the shorthand, the block does one of three things. It can send one message to the named core. It can raise a request at the local core without using the bus. It can send a message to every other core, with or without the local request as well.

Bus messages leave one at a time over a valid/ready request channel. Each message carries the target core ID and the written payload. Every message is later answered by a one-cycle acknowledge pulse. An in-flight counter is loaded with the full message count of the write. A delivery-status busy flag stays high until the last acknowledge has come back. While the flag is high, further command writes are dropped.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `busy`, `msg_valid` and `self_req` are all low.
- R2: Shorthand code 0 sends exactly one message whose `msg_target` equals `cmd_dest`. Every message carries the written vector, mode and trigger.
- R3: Shorthand code 1 produces a one-cycle `self_req` pulse in the cycle after the write. The pulse carries the written vector, mode and trigger. No message is sent and `busy` stays low.
- R4: Shorthand code 2 produces the same `self_req` pulse as code 1. It also sends one message to every core except `LOCAL_ID`.
- R5: Shorthand code 3 sends one message to every core except `LOCAL_ID` and gives no `self_req` pulse.
- R6: Messages are issued at most one per accepted handshake, in ascending target order. While `msg_valid` is high and `msg_ready` is low, the target and payload hold.
- R7: A write that sends at least one message raises `busy` in the following cycle. `busy` stays high until the number of `msg_ack` pulses equals the number of messages. It falls in the cycle after the final acknowledge.
- R8: A command write made while `busy` is high is ignored. It causes no `self_req`, no extra message, and no extra acknowledge is needed before `busy` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_short | input | 2 | Destination shorthand (0 named, 1 self, 2 all, 3 others) |
| cmd_dest | input | CORE_W | Destination core ID for shorthand 0 |
| cmd_vector | input | VEC_W | Interrupt vector |
| cmd_mode | input | MODE_W | Delivery mode |
| cmd_trig | input | 1 | Trigger mode |
| busy | output | 1 | Delivery status, high while acknowledges are outstanding |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Interconnect accepts the message |
| msg_target | output | CORE_W | Target core ID |
| msg_vector | output | VEC_W | Message vector |
| msg_mode | output | MODE_W | Message delivery mode |
| msg_trig | output | 1 | Message trigger mode |
| msg_ack | input | 1 | One acknowledge per delivered message |
| self_req | output | 1 | Local interrupt request pulse |
| self_vector | output | VEC_W | Local request vector |
| self_mode | output | MODE_W | Local request delivery mode |
| self_trig | output | 1 | Local request trigger mode |

## Verification
The hardest case to reach is a broadcast that stalls partway through. In this case the channel holds its target under backpressure while some acknowledges have already returned. The busy flag must then survive every acknowledge except the last. The bench reaches this case by holding `msg_ready` low across a broadcast start. It returns acknowledges one at a time and samples `busy` just before and just after the final one. It also issues a broadcast write while a unicast is still outstanding. Any wrongly accepted write would leave the counter too high, so `busy` would fail to clear after the single acknowledge.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int unsigned VEC_W  = 8;
   localparam int unsigned MODE_W = 3;

   typedef enum logic [1:0] {
      SH_NAMED  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [MODE_W-1:0] mode;
      logic              trig;
   } ipi_payload_t;
endpackage

// File: rtl/ipi_short_decode.sv
module ipi_short_decode
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned CNT_W     = 3
) (
   input  shorthand_e       sh,
   output logic             want_self,
   output logic             want_bus,
   output logic             is_bcast,
   output logic [CNT_W-1:0] n_msgs
);
   localparam logic [CNT_W-1:0] OTHERS_N = CNT_W'(NUM_CORES - 1);

   always_comb begin
      want_self = 1'b0;
      want_bus  = 1'b0;
      is_bcast  = 1'b0;
      n_msgs    = '0;
      unique case (sh)
         SH_NAMED: begin
            want_bus = 1'b1;
            n_msgs   = CNT_W'(1);
         end
         SH_SELF: want_self = 1'b1;
         SH_ALL: begin
            want_self = 1'b1;
            want_bus  = 1'b1;
            is_bcast  = 1'b1;
            n_msgs    = OTHERS_N;
         end
         SH_OTHERS: begin
            want_bus = 1'b1;
            is_bcast = 1'b1;
            n_msgs   = OTHERS_N;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ipi_target_seq.sv
module ipi_target_seq #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned LOCAL_ID  = 1,
   parameter int unsigned CORE_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_bcast,
   input  logic [CORE_W-1:0] start_dest,
   input  logic              msg_ready,
   output logic              msg_valid,
   output logic [CORE_W-1:0] msg_target
);
   localparam logic [CORE_W:0]   LID_X   = (CORE_W+1)'(LOCAL_ID);
   localparam logic [CORE_W:0]   NCORE_X = (CORE_W+1)'(NUM_CORES);
   localparam logic [CORE_W-1:0] FIRST   = (LOCAL_ID == 0) ? CORE_W'(1) : CORE_W'(0);

   logic              active_q, bcast_q;
   logic [CORE_W-1:0] tgt_q;
   logic [CORE_W:0]   step;
   logic              last;
   logic              fire;

   assign fire = active_q & msg_ready;

   always_comb begin
      step = {1'b0, tgt_q} + 1'b1;
      if (step == LID_X) step = step + 1'b1;
      last = (step >= NCORE_X);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bcast_q  <= 1'b0;
         tgt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         bcast_q  <= start_bcast;
         tgt_q    <= start_bcast ? FIRST : start_dest;
      end else if (fire) begin
         if (!bcast_q || last) begin
            active_q <= 1'b0;
         end else begin
            tgt_q <= step[CORE_W-1:0];
         end
      end
   end

   assign msg_valid  = active_q;
   assign msg_target = tgt_q;

   a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_target));
   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      fire && bcast_q && !last |=> msg_target > $past(msg_target));
   a_r5_skip_local: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && bcast_q |-> msg_target != CORE_W'(LOCAL_ID));
   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> {1'b0, msg_target} < NCORE_X);
endmodule

// File: rtl/ipi_flight_ctr.sv
module ipi_flight_ctr #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_n,
   input  logic             ack,
   output logic             busy
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + (load ? load_n : '0) - CNT_W'(ack);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (load && load_n != '0) begin
         busy_q <= 1'b1;
      end else if (ack && cnt_q == CNT_W'(1)) begin
         busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;

   a_r7_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt_q != '0);
   a_r7_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cnt_q == '0);
   a_r7_ack_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> busy);
   a_r8_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> cnt_q == '0);
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned LOCAL_ID  = 1,
   parameter int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [1:0]        cmd_short,
   input  logic [CORE_W-1:0] cmd_dest,
   input  logic [VEC_W-1:0]  cmd_vector,
   input  logic [MODE_W-1:0] cmd_mode,
   input  logic              cmd_trig,
   output logic              busy,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [CORE_W-1:0] msg_target,
   output logic [VEC_W-1:0]  msg_vector,
   output logic [MODE_W-1:0] msg_mode,
   output logic              msg_trig,
   input  logic              msg_ack,
   output logic              self_req,
   output logic [VEC_W-1:0]  self_vector,
   output logic [MODE_W-1:0] self_mode,
   output logic              self_trig
);
   localparam int unsigned CNT_W = $clog2(NUM_CORES) + 1;

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("ipi_dispatch: NUM_CORES must be at least 2");
   end
   if (LOCAL_ID >= NUM_CORES) begin : g_bad_local
      $error("ipi_dispatch: LOCAL_ID must be below NUM_CORES");
   end
   if ((1 << CORE_W) < NUM_CORES) begin : g_bad_width
      $error("ipi_dispatch: CORE_W too narrow for NUM_CORES");
   end

   logic             accept;
   logic             want_self, want_bus, is_bcast;
   logic [CNT_W-1:0] n_msgs;
   ipi_payload_t     pay_q;
   logic             self_q;

   assign accept = cmd_we & ~busy;

   ipi_short_decode #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_dec (
      .sh        (shorthand_e'(cmd_short)),
      .want_self (want_self),
      .want_bus  (want_bus),
      .is_bcast  (is_bcast),
      .n_msgs    (n_msgs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pay_q  <= '0;
         self_q <= 1'b0;
      end else begin
         self_q <= accept & want_self;
         if (accept) pay_q <= '{vector: cmd_vector, mode: cmd_mode, trig: cmd_trig};
      end
   end

   ipi_target_seq #(.NUM_CORES(NUM_CORES), .LOCAL_ID(LOCAL_ID), .CORE_W(CORE_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept & want_bus),
      .start_bcast (is_bcast),
      .start_dest  (cmd_dest),
      .msg_ready   (msg_ready),
      .msg_valid   (msg_valid),
      .msg_target  (msg_target)
   );

   ipi_flight_ctr #(.CNT_W(CNT_W)) u_flight (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .load_n (n_msgs),
      .ack    (msg_ack),
      .busy   (busy)
   );

   assign msg_vector  = pay_q.vector;
   assign msg_mode    = pay_q.mode;
   assign msg_trig    = pay_q.trig;
   assign self_req    = self_q;
   assign self_vector = pay_q.vector;
   assign self_mode   = pay_q.mode;
   assign self_trig   = pay_q.trig;

   a_r3_self_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      self_req |-> $past(cmd_we) && !$past(busy) && $past(cmd_short[1] | cmd_short[0])
                   && $past(cmd_short) != 2'd3);
   a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_we |=> !self_req);
   a_r7_valid_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> busy);
   a_r3_self_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && !busy && cmd_short == 2'd1 |=> !busy && !msg_valid);
endmodule

// File: tb/ipi_dispatch_test.sv
`timescale 1ns/1ps
module ipi_dispatch_test;
   localparam int NC   = 4;
   localparam int LID  = 1;
   localparam int CW   = 2;
   localparam logic [3:0] OTHERS = 4'b1101;

   // {exp_self, exp_mask[3:0], short[1:0], dest[1:0], trig, mode[2:0], vector[7:0]}
   localparam logic [20:0] VECS [8] = '{
      {1'b0, 4'b0100, 2'd0, 2'd2, 1'b0, 3'd0, 8'h41},
      {1'b1, 4'b0000, 2'd1, 2'd0, 1'b1, 3'd4, 8'h52},
      {1'b1, 4'b1101, 2'd2, 2'd3, 1'b0, 3'd1, 8'h63},
      {1'b0, 4'b1101, 2'd3, 2'd0, 1'b1, 3'd2, 8'h74},
      {1'b0, 4'b0010, 2'd0, 2'd1, 1'b1, 3'd5, 8'h85},
      {1'b0, 4'b0001, 2'd0, 2'd0, 1'b0, 3'd0, 8'h96},
      {1'b0, 4'b1101, 2'd3, 2'd2, 1'b0, 3'd7, 8'hA7},
      {1'b1, 4'b0000, 2'd1, 2'd3, 1'b1, 3'd7, 8'hFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [1:0]    cmd_short = '0;
   logic [CW-1:0] cmd_dest = '0;
   logic [7:0]    cmd_vector = '0;
   logic [2:0]    cmd_mode = '0;
   logic          cmd_trig = 1'b0;
   logic          busy, msg_valid, msg_trig, self_req, self_trig;
   logic          msg_ready = 1'b1;
   logic          msg_ack = 1'b0;
   logic [CW-1:0] msg_target;
   logic [7:0]    msg_vector, self_vector;
   logic [2:0]    msg_mode, self_mode;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ipi_dispatch #(.NUM_CORES(NC), .LOCAL_ID(LID)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_short(cmd_short),
      .cmd_dest(cmd_dest), .cmd_vector(cmd_vector), .cmd_mode(cmd_mode),
      .cmd_trig(cmd_trig), .busy(busy), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_target(msg_target), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_trig(msg_trig), .msg_ack(msg_ack),
      .self_req(self_req), .self_vector(self_vector), .self_mode(self_mode),
      .self_trig(self_trig)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] sh, input logic [1:0] dst,
                        input logic tr, input logic [2:0] md, input logic [7:0] vc);
      @(negedge clk);
      cmd_we = 1'b1; cmd_short = sh; cmd_dest = dst;
      cmd_trig = tr; cmd_mode = md; cmd_vector = vc;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   // Watches 12 cycles from the current negedge, recording messages and self pulses.
   task automatic collect(input logic [11:0] pay, output logic [3:0] mask, output int n,
                          output logic ordered, output logic pay_ok,
                          output int nself, output logic self_ok);
      int last_t = -1;
      mask = '0; n = 0; ordered = 1'b1; pay_ok = 1'b1; nself = 0; self_ok = 1'b1;
      for (int c = 0; c < 12; c++) begin
         if (self_req) begin
            nself++;
            if ({self_trig, self_mode, self_vector} !== pay) self_ok = 1'b0;
         end
         if (msg_valid && msg_ready) begin
            if (int'(msg_target) <= last_t) ordered = 1'b0;
            last_t = int'(msg_target);
            mask[msg_target] = 1'b1;
            if ({msg_trig, msg_mode, msg_vector} !== pay) pay_ok = 1'b0;
            n++;
         end
         @(negedge clk);
      end
   endtask

   task automatic acks(input int n);
      for (int i = 0; i < n; i++) begin
         if (i == n - 1) check("R7 busy before last ack", busy, 1);
         msg_ack = 1'b1;
         @(negedge clk);
         msg_ack = 1'b0;
         @(negedge clk);
      end
      check("R7 busy after last ack", busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [3:0] mask;
      int n, nself;
      logic ordered, pay_ok, self_ok;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", busy, 0);
      check("R1 msg_valid", msg_valid, 0);
      check("R1 self_req", self_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         logic [20:0] e = VECS[v];
         string tag;
         case (e[15:14])
            2'd0: tag = "R2";
            2'd1: tag = "R3";
            2'd2: tag = "R4";
            default: tag = "R5";
         endcase
         issue(e[15:14], e[13:12], e[11], e[10:8], e[7:0]);
         check("R7 busy after write", busy, (e[19:16] != 0));
         collect(e[11:0], mask, n, ordered, pay_ok, nself, self_ok);
         check({tag, " target set"}, mask, e[19:16]);
         check({tag, " message count"}, n, $countones(e[19:16]));
         check("R6 ascending order", ordered, 1);
         check("R2 message payload", pay_ok, 1);
         check({tag, " self pulse count"}, nself, e[20]);
         check("R3 self payload", self_ok, 1);
         if (n > 0) acks(n);
         else check("R3 busy stays low", busy, 0);
      end

      // R6: backpressure on broadcast start holds the target
      msg_ready = 1'b0;
      issue(2'd3, 2'd0, 1'b1, 3'd3, 8'h3C);
      check("R6 valid under stall", msg_valid, 1);
      check("R6 first target", msg_target, 0);
      repeat (3) @(negedge clk);
      check("R6 valid held", msg_valid, 1);
      check("R6 target held", msg_target, 0);
      check("R6 payload held", {msg_trig, msg_mode, msg_vector}, {1'b1, 3'd3, 8'h3C});
      msg_ready = 1'b1;
      collect({1'b1, 3'd3, 8'h3C}, mask, n, ordered, pay_ok, nself, self_ok);
      check("R5 target set after stall", mask, OTHERS);
      check("R6 order after stall", ordered, 1);
      acks(n);

      // R8: write while busy is dropped
      issue(2'd0, 2'd3, 1'b0, 3'd1, 8'h11);
      collect({1'b0, 3'd1, 8'h11}, mask, n, ordered, pay_ok, nself, self_ok);
      check("R2 unicast to 3", mask, 4'b1000);
      issue(2'd2, 2'd0, 1'b1, 3'd6, 8'h22);
      check("R8 no self pulse", self_req, 0);
      check("R8 no message", msg_valid, 0);
      repeat (3) @(negedge clk);
      check("R8 still no message", msg_valid, 0);
      acks(1);

      // R3: back-to-back self writes give two pulses
      issue(2'd1, 2'd0, 1'b0, 3'd2, 8'h5A);
      check("R3 first pulse", self_req, 1);
      issue(2'd1, 2'd0, 1'b1, 3'd0, 8'hA5);
      check("R3 second pulse", self_req, 1);
      check("R3 second payload", {self_trig, self_mode, self_vector}, {1'b1, 3'd0, 8'hA5});
      @(negedge clk);
      check("R3 pulse ends", self_req, 0);
      check("R3 no busy", busy, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule